// File: doc/BRIEF.md
# ECC-Protected Dual-Port Mailbox RAM

Two safety channels exchange their results through this block: a four-word, 32-bit memory reachable from two independent ports. Port A is an APB slave used by the local comparison logic. Port B is a plain request/write-enable slave standing in for the processor side. Each channel owns one payload word and one status word. In a status word, bit 0 set means the channel's data is valid and waiting to be compared, and bit 1 set means that channel has finished its comparison. The block stores these words without interpreting them.

Every stored word is kept as a 39-bit codeword: 32 data bits, six Hamming check bits and one overall parity bit. Check bits are generated on every write and checked on every read. A single flipped bit is corrected on the way out, and operation continues. Two flipped bits are reported as uncorrectable. Any uncorrectable read sets a complementary fault pair that holds its value until the dedicated active-low safety reset is applied. A test input can XOR a mask into a stored codeword, so that correction and detection can be exercised. When both ports write the same word in the same cycle, port A wins, and a sticky collision flag records the event.

Top module: `mbox_ecc_ram`

## Requirements
- R1: Word index is address bits [3:2], so byte addresses 0x0, 0x4, 0x8 and 0xC select words 0 to 3 (local payload, local status, remote payload, remote status). A word written through either port reads back unchanged through either port.
- R2: An APB transfer has a setup cycle (PSEL=1, PENABLE=0) followed by an access phase. In the first access cycle PREADY is 0. In the second access cycle PREADY is 1, PRDATA is valid for a read, and a write takes effect at the clock edge that ends this cycle.
- R3: On port B, a write is stored at the clock edge where b_req=1 and b_we=1. A read with b_req=1 and b_we=0 returns b_rdata with b_rvalid=1 in the following cycle. In any other cycle b_rvalid is 0.
- R4: A stored codeword with exactly one flipped bit, at any of the 39 positions, reads back with the original data, with no PSLVERR, no b_rerr and no change to the fault pair.
- R5: A read of a codeword with exactly two flipped bits completes with PSLVERR=1 (port A) or b_rerr=1 (port B). fault_p=1 and fault_n=0 hold from the cycle in which that error is reported.
- R6: fault_n is always the complement of fault_p. Once the fault is set, it stays set through later writes and through rst_n, and only safety_rst_n=0 clears it (fault_p=0, fault_n=1).
- R7: If port A and port B write the same word in the same cycle, the port A data is stored and collide_seen becomes 1. collide_seen stays 1 until safety_rst_n=0. Writes to different words in the same cycle both take effect and do not set the flag.
- R8: With inj_en=1, the bit mask inj_mask (bit k is codeword position k, 0 to 38) is XORed into the word at index inj_addr at the clock edge. A write to that word in the same cycle takes priority, and any later write stores a clean codeword.
- R9: rst_n=0 clears all four words to zero and drives PREADY, PSLVERR, b_rvalid and b_rerr to 0. PSLVERR is 0 on writes and on reads of correctable words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for storage and port logic |
| safety_rst_n | input | 1 | Active-low reset for the fault pair and collision flag |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 4 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error, set on an uncorrectable read |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 4 | Port B byte address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_rerr | output | 1 | Port B uncorrectable read |
| inj_en | input | 1 | Test corruption enable |
| inj_addr | input | 2 | Word index to corrupt |
| inj_mask | input | 39 | Codeword bits to flip |
| fault_p | output | 1 | Latched fault, true rail |
| fault_n | output | 1 | Latched fault, complement rail |
| collide_seen | output | 1 | Sticky same-word write collision flag |

## Verification
Corrupted storage cannot be reached from the data ports at all, because every write stores a clean codeword. The bench therefore drives the corruption input with one-bit and two-bit masks on words whose flip state it tracks, and it never corrupts a word that is already corrupted. Its expected result depends only on how many bits are flipped, not on the code itself. A same-word collision needs the port B write to land exactly on the APB ready cycle, so a dedicated task raises b_req on that cycle. Injection on the same edge as a write is also forced directly.

// File: rtl/mbox_ecc_pkg.sv
package mbox_ecc_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int CW_W   = DATA_W + CHK_W + 1;

    typedef logic [CW_W-1:0] cw_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              uncorr;
    } dec_t;

    function automatic logic is_pow2(input int i);
        return (i & (i - 1)) == 0;
    endfunction

    // codeword index equals Hamming position; index 0 holds overall parity
    function automatic cw_t ecc_encode(input logic [DATA_W-1:0] d);
        cw_t  cw;
        int   k;
        logic x;
        cw = '0;
        k  = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                cw[i] = d[k];
                k++;
            end
        end
        for (int p = 0; p < CHK_W; p++) begin
            x = 1'b0;
            for (int i = 1; i < CW_W; i++) begin
                if ((i & (1 << p)) != 0) x = x ^ cw[i];
            end
            cw[1 << p] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic dec_t ecc_decode(input cw_t cw);
        dec_t             r;
        cw_t              fixed;
        logic [CHK_W-1:0] syn;
        logic             overall;
        int               k;
        syn = '0;
        for (int p = 0; p < CHK_W; p++) begin
            for (int i = 1; i < CW_W; i++) begin
                if ((i & (1 << p)) != 0) syn[p] = syn[p] ^ cw[i];
            end
        end
        overall  = ^cw;
        fixed    = cw;
        r.uncorr = 1'b0;
        if (overall) begin
            if (int'(syn) < CW_W) fixed[syn] = ~fixed[syn];
            else                  r.uncorr   = 1'b1;
        end else if (syn != '0) begin
            r.uncorr = 1'b1;
        end
        r.data = '0;
        k      = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                r.data[k] = fixed[i];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mbox_ecc_enc.sv
module mbox_ecc_enc
    import mbox_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   cw
);
    always_comb begin
        cw = ecc_encode(data);
    end
endmodule

// File: rtl/mbox_ecc_dec.sv
module mbox_ecc_dec
    import mbox_ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              uncorr
);
    dec_t res;
    always_comb begin
        res    = ecc_decode(cw);
        data   = res.data;
        uncorr = res.uncorr;
    end
endmodule

// File: rtl/mbox_apb_port.sv
module mbox_apb_port #(
    parameter int IDX_W  = 2,
    parameter int ADDR_W = IDX_W + 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_uncorr,
    output logic              rd_sample,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic              waited;
        logic [DATA_W-1:0] rdata;
        logic              rerr;
    } apb_t;

    apb_t apb_d, apb_q;
    logic access;
    logic unused_addr;

    assign unused_addr = ^paddr[1:0];
    assign access      = psel & penable;

    always_comb begin
        apb_d = apb_q;
        if (access && !apb_q.waited) begin
            apb_d.waited = 1'b1;
            apb_d.rdata  = rd_data;
            apb_d.rerr   = rd_uncorr & ~pwrite;
        end else begin
            apb_d.waited = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) apb_q <= '0;
        else        apb_q <= apb_d;
    end

    assign idx       = paddr[ADDR_W-1:2];
    assign pready    = access & apb_q.waited;
    assign prdata    = apb_q.rdata;
    assign pslverr   = pready & apb_q.rerr & ~pwrite;
    assign rd_sample = access & ~apb_q.waited & ~pwrite;
    assign wr_en     = pready & pwrite;
    assign wr_data   = pwdata;
endmodule

// File: rtl/mbox_ecc_ram.sv
module mbox_ecc_ram
    import mbox_ecc_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              safety_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_rerr,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_addr,
    input  logic [CW_W-1:0]   inj_mask,
    output logic              fault_p,
    output logic              fault_n,
    output logic              collide_seen
);
    typedef struct packed {
        logic [DEPTH-1:0][CW_W-1:0] mem;
        logic [DATA_W-1:0]          b_rdata;
        logic                       b_rvalid;
        logic                       b_rerr;
    } main_t;

    typedef struct packed {
        logic fault;
        logic collide;
    } safe_t;

    main_t main_d, main_q;
    safe_t safe_d, safe_q;

    logic [IDX_W-1:0]  a_idx, b_idx;
    logic              a_wr_en, a_rd_sample;
    logic [DATA_W-1:0] a_wdata;
    logic [CW_W-1:0]   a_cw, b_cw;
    logic [DATA_W-1:0] a_rdata, b_dec_data;
    logic              a_uncorr, b_uncorr;
    logic              b_wr, b_rd;
    logic              unused_baddr;

    assign unused_addr_b = 1'b0;
    assign unused_baddr  = ^b_addr[1:0];
    assign b_idx         = b_addr[ADDR_W-1:2];
    assign b_wr          = b_req & b_we;
    assign b_rd          = b_req & ~b_we;

    mbox_apb_port #(
        .IDX_W (IDX_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_apb (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pready   (pready),
        .pslverr  (pslverr),
        .idx      (a_idx),
        .rd_data  (a_rdata),
        .rd_uncorr(a_uncorr),
        .rd_sample(a_rd_sample),
        .wr_en    (a_wr_en),
        .wr_data  (a_wdata)
    );

    mbox_ecc_enc u_enc_a (.data(a_wdata), .cw(a_cw));
    mbox_ecc_enc u_enc_b (.data(b_wdata), .cw(b_cw));

    mbox_ecc_dec u_dec_a (.cw(main_q.mem[a_idx]), .data(a_rdata),    .uncorr(a_uncorr));
    mbox_ecc_dec u_dec_b (.cw(main_q.mem[b_idx]), .data(b_dec_data), .uncorr(b_uncorr));

    always_comb begin
        main_d          = main_q;
        main_d.b_rvalid = b_rd;
        main_d.b_rerr   = b_rd & b_uncorr;
        if (b_rd) main_d.b_rdata = b_dec_data;
        for (int e = 0; e < DEPTH; e++) begin
            if (a_wr_en && a_idx == IDX_W'(e)) begin
                main_d.mem[e] = a_cw;
            end else if (b_wr && b_idx == IDX_W'(e)) begin
                main_d.mem[e] = b_cw;
            end else if (inj_en && inj_addr == IDX_W'(e)) begin
                main_d.mem[e] = main_q.mem[e] ^ inj_mask;
            end
        end
    end

    always_comb begin
        safe_d         = safe_q;
        safe_d.fault   = safe_q.fault | (a_rd_sample & a_uncorr) | (b_rd & b_uncorr);
        safe_d.collide = safe_q.collide | (a_wr_en & b_wr & (a_idx == b_idx));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) main_q <= '0;
        else        main_q <= main_d;
    end

    always_ff @(posedge clk or negedge safety_rst_n) begin
        if (!safety_rst_n) safe_q <= '0;
        else               safe_q <= safe_d;
    end

    assign b_rdata      = main_q.b_rdata;
    assign b_rvalid     = main_q.b_rvalid;
    assign b_rerr       = main_q.b_rerr;
    assign fault_p      = safe_q.fault;
    assign fault_n      = ~safe_q.fault;
    assign collide_seen = safe_q.collide;

    logic unused_addr_b;
endmodule

// File: rtl/mbox_ecc_ram_chk.sv
module mbox_ecc_ram_chk (
    input logic clk,
    input logic rst_n,
    input logic safety_rst_n,
    input logic psel,
    input logic penable,
    input logic pwrite,
    input logic pready,
    input logic pslverr,
    input logic b_req,
    input logic b_we,
    input logic b_rvalid,
    input logic fault_p,
    input logic fault_n,
    input logic collide_seen
);
    AST_FAULT_COMPL: assert property (@(posedge clk) disable iff (!safety_rst_n)
        fault_p != fault_n); // R6

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!safety_rst_n)
        fault_p |=> fault_p); // R6

    AST_PREADY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !$past(psel && penable)) |-> !pready); // R2

    AST_PREADY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=> (psel && penable) |-> pready); // R2

    AST_SLVERR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (pready && !pwrite)); // R9

    AST_B_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_we) |=> b_rvalid); // R3

    AST_B_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_req && !b_we) |=> !b_rvalid); // R3

    AST_COLLIDE_STICKY: assert property (@(posedge clk) disable iff (!safety_rst_n)
        collide_seen |=> collide_seen); // R7
endmodule

bind mbox_ecc_ram mbox_ecc_ram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .safety_rst_n(safety_rst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .pready      (pready),
    .pslverr     (pslverr),
    .b_req       (b_req),
    .b_we        (b_we),
    .b_rvalid    (b_rvalid),
    .fault_p     (fault_p),
    .fault_n     (fault_n),
    .collide_seen(collide_seen)
);

// File: tb/mbox_ecc_ram_test.sv
`timescale 1ns/1ps
module mbox_ecc_ram_test;
    localparam int CW = 39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, safety_rst_n = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [3:0]  paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        b_req = 0, b_we = 0;
    logic [3:0]  b_addr = 0;
    logic [31:0] b_wdata = 0;
    logic [31:0] b_rdata;
    logic        b_rvalid, b_rerr;
    logic        inj_en = 0;
    logic [1:0]  inj_addr = 0;
    logic [CW-1:0] inj_mask = 0;
    logic        fault_p, fault_n, collide_seen;

    int vectors = 0, fails = 0;
    logic [31:0]   mem_m  [4];
    logic [CW-1:0] mask_m [4];
    logic          exp_fault = 0, exp_coll = 0;

    always #10 clk = ~clk;

    mbox_ecc_ram uut (.*);

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_err(input int idx);
        return $countones(mask_m[idx]) >= 2;
    endfunction

    task automatic check_flags(input string req);
        check(req, "fault_p", {63'd0, fault_p}, {63'd0, exp_fault});
        check("R6", "fault_n", {63'd0, fault_n}, {63'd0, ~exp_fault});
        check("R7", "collide_seen", {63'd0, collide_seen}, {63'd0, exp_coll});
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            mem_m[i]  = '0;
            mask_m[i] = '0;
        end
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        model_clear();
    endtask

    task automatic pulse_safety_rst();
        @(negedge clk); safety_rst_n = 0;
        @(negedge clk); safety_rst_n = 1;
        exp_fault = 0; exp_coll = 0;
    endtask

    task automatic apb_read(input int idx, input string req);
        logic e;
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 4'(idx * 4);
        @(negedge clk); penable = 1; #1;
        check("R2", "pready first access", {63'd0, pready}, 64'd0);
        @(negedge clk);
        e = exp_err(idx);
        check("R2", "pready second access", {63'd0, pready}, 64'd1);
        check(e ? "R5" : "R9", "pslverr", {63'd0, pslverr}, {63'd0, e});
        if (!e) check(req, "prdata", {32'd0, prdata}, {32'd0, mem_m[idx]});
        if (e) exp_fault = 1;
        check(e ? "R5" : req, "fault after A read", {63'd0, fault_p}, {63'd0, exp_fault});
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic apb_write(input int idx, input logic [31:0] d, input logic coll, input int bidx, input logic [31:0] bd);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 4'(idx * 4); pwdata = d;
        @(negedge clk); penable = 1; #1;
        check("R2", "pready first access (wr)", {63'd0, pready}, 64'd0);
        @(negedge clk);
        check("R2", "pready second access (wr)", {63'd0, pready}, 64'd1);
        check("R9", "pslverr on write", {63'd0, pslverr}, 64'd0);
        if (coll) begin
            b_req = 1; b_we = 1; b_addr = 4'(bidx * 4); b_wdata = bd;
        end
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; b_req = 0; b_we = 0;
        if (coll) begin
            mem_m[bidx] = bd; mask_m[bidx] = '0;
            if (bidx == idx) exp_coll = 1;
        end
        mem_m[idx] = d; mask_m[idx] = '0;
    endtask

    task automatic b_write(input int idx, input logic [31:0] d, input logic inj);
        @(negedge clk); b_req = 1; b_we = 1; b_addr = 4'(idx * 4); b_wdata = d;
        if (inj) begin
            inj_en = 1; inj_addr = 2'(idx); inj_mask = 39'h3;
        end
        @(negedge clk); b_req = 0; b_we = 0; inj_en = 0;
        mem_m[idx] = d; mask_m[idx] = '0;
    endtask

    task automatic b_read(input int idx, input string req);
        logic e;
        @(negedge clk); b_req = 1; b_we = 0; b_addr = 4'(idx * 4);
        @(negedge clk);
        b_req = 0;
        e = exp_err(idx);
        check("R3", "b_rvalid", {63'd0, b_rvalid}, 64'd1);
        check(e ? "R5" : "R4", "b_rerr", {63'd0, b_rerr}, {63'd0, e});
        if (!e) check(req, "b_rdata", {32'd0, b_rdata}, {32'd0, mem_m[idx]});
        if (e) exp_fault = 1;
        check(e ? "R5" : req, "fault after B read", {63'd0, fault_p}, {63'd0, exp_fault});
        @(negedge clk);
        check("R3", "b_rvalid idle", {63'd0, b_rvalid}, 64'd0);
    endtask

    task automatic inject(input int idx, input logic [CW-1:0] m);
        @(negedge clk); inj_en = 1; inj_addr = 2'(idx); inj_mask = m;
        @(negedge clk); inj_en = 0;
        mask_m[idx] = mask_m[idx] ^ m;
    endtask

    function automatic logic [CW-1:0] rand_mask(input int nbits);
        int p, q;
        p = int'($urandom_range(CW - 1));
        q = p;
        while (q == p) q = int'($urandom_range(CW - 1));
        return (CW'(1) << p) | ((nbits == 2) ? (CW'(1) << q) : CW'(0));
    endfunction

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1; safety_rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check("R9", "pready reset", {63'd0, pready}, 64'd0);
        check("R9", "b_rvalid reset", {63'd0, b_rvalid}, 64'd0);
        check("R9", "b_rerr reset", {63'd0, b_rerr}, 64'd0);
        check_flags("R6");
        for (int i = 0; i < 4; i++) apb_read(i, "R9");

        // R1 cross-port traffic at every address
        for (int i = 0; i < 4; i++) begin
            apb_write(i, 32'hA5A0_0000 + 32'(i), 0, 0, 0);
            b_read(i, "R1");
        end
        for (int i = 0; i < 4; i++) begin
            b_write(i, 32'h0000_0003 ^ (32'(i) << 20), 0);
            apb_read(i, "R1");
        end

        // R4 single flips: parity bit, a check bit, a data bit, top bit
        inject(0, 39'h1);        b_read(0, "R4"); apb_read(0, "R4");
        inject(1, 39'h10);       b_read(1, "R4"); apb_read(1, "R4");
        inject(2, 39'h8);        apb_read(2, "R4");
        inject(3, 39'h40_0000_0000); b_read(3, "R4");
        check_flags("R4");

        // R5 double flip, R8 rewrite clears it, R6 sticky
        apb_write(0, 32'h1234_5678, 0, 0, 0);
        inject(0, 39'h6);
        apb_read(0, "R5");
        check_flags("R5");
        b_write(0, 32'hCAFE_F00D, 0);
        apb_read(0, "R8");
        check_flags("R6");
        pulse_rst();
        check_flags("R6");
        b_read(2, "R9");
        pulse_safety_rst();
        check_flags("R6");

        // R5 via port B
        b_write(3, 32'h0BAD_0001, 0);
        inject(3, 39'h3000);
        b_read(3, "R5");
        pulse_safety_rst();

        // R7 collisions
        apb_write(1, 32'h1111_1111, 1, 2, 32'h2222_2222);
        check_flags("R7");
        apb_read(1, "R7"); apb_read(2, "R7");
        apb_write(2, 32'hAAAA_0002, 1, 2, 32'hBBBB_0002);
        check_flags("R7");
        b_read(2, "R7");

        // R8 write wins over same-cycle injection
        b_write(1, 32'h5555_AAAA, 1);
        apb_read(1, "R8");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op, idx;
            op  = int'($urandom_range(5));
            idx = int'($urandom_range(3));
            case (op)
                0: apb_write(idx, $urandom, 0, 0, 0);
                1: b_write(idx, $urandom, 0);
                2: apb_read(idx, "R1");
                3: b_read(idx, "R1");
                default: if (mask_m[idx] == '0) inject(idx, rand_mask(op == 4 ? 1 : 2));
            endcase
        end
        check_flags("R6");
        pulse_safety_rst();
        check_flags("R7");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule